// File: doc/BRIEF.md
# SHA-256 Four-Round Compression Step

This block advances a SHA-256 working state by four compression rounds in one operation. The eight state words are carried as two 128-bit operands: one holds words a..d and the other holds words e..h. A third 128-bit operand carries four 32-bit words, each already the sum of a message-schedule word and its round constant. One lane is consumed per round, lane 0 first. The result is one 128-bit half of the updated state.

A mode bit selects between two variants. In the first-half variant, the destination operand is taken as a..d and the source operand as e..h, and the block returns the new a..d. In the second-half variant, the two roles are exchanged and the block returns the new e..h. Software that runs both variants on the same pair of registers obtains the complete updated state after four rounds.

The unit runs one round per clock. A finite-state machine with three states controls it. IDLE waits for work. RUN executes the rounds. DONE signals completion for one cycle. The transitions are named as follows. Launch: IDLE to RUN on start, which latches the operands. Step: RUN to RUN while the round index is below 3. Finish: RUN to DONE after round 3. Retire: DONE to IDLE unconditionally. Any state returns to IDLE on reset.

Top module: `sha256_quad_round`

## Requirements
- R1: Synchronous active-high reset puts the unit in IDLE, holds `done` low and makes `result` read zero. A reset in the middle of an operation abandons it, and no `done` follows.
- R2: With `part2` = 0 at launch, `dst_in` supplies words a..d and `src_in` supplies words e..h. The returned value is the updated a..d.
- R3: With `part2` = 1 at launch, `src_in` supplies a..d and `dst_in` supplies e..h. The returned value is the updated e..h.
- R4: Each round forms T1 = h + Σ1(e) + Ch(e,f,g) + k and T2 = Σ0(a) + Maj(a,b,c), all modulo 2^32. Σ1 is the XOR of rotate-right by 6, 11 and 25. Σ0 is the XOR of rotate-right by 2, 13 and 22. Ch takes f where e is 1 and g where e is 0. Maj is the bitwise majority.
- R5: Lane i of every 128-bit operand occupies bits [32i+31:32i]. Word a is lane 0 and word d is lane 3 of the a..d operand; the same holds for e and h. Round i consumes lane i of `wk_in`.
- R6: `done` is high for exactly one cycle. It is sampled high at the fifth rising edge after the edge that accepted `start`.
- R7: `result` holds its value from the `done` cycle until the next accepted start.
- R8: A `start` asserted in RUN or DONE is ignored. The running operation completes with its original operands, and no extra operation follows.
- R9: All-zero state and key operands produce an all-zero result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch request, accepted only in IDLE |
| part2 | input | 1 | Variant select: 0 first half, 1 second half |
| dst_in | input | 128 | Destination state half (a..d or e..h by mode) |
| src_in | input | 128 | Source state half (e..h or a..d by mode) |
| wk_in | input | 128 | Four schedule-plus-constant words, lane 0 first |
| done | output | 1 | One-cycle completion pulse |
| result | output | 128 | Updated state half selected by the mode |

## Verification
The vectors use a known initial hash state under both variants, so a design that fails to swap the operand roles, or returns the wrong half, produces a result that does not match. Two key operands put a single nonzero word in lane 0 and then in lane 3. A design that reverses the lane order, or drops the rotation between rounds, therefore produces different bits. A start is injected mid-run and again in the DONE cycle: a design that restarts would return the wrong value or emit a second `done`. A reset during a run must suppress the pending `done`. Sampling `done` on each cycle catches a pulse that arrives early, arrives late, or lasts two cycles.

// File: rtl/sha4r_pkg.sv
package sha4r_pkg;

    localparam int WORD_W = 32;
    localparam int LANES  = 4;
    localparam int QUAD_W = WORD_W * LANES;
    localparam int CNT_W  = $clog2(LANES);

    typedef logic [WORD_W-1:0]            word_t;
    typedef logic [LANES-1:0][WORD_W-1:0] quad_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } state_t;

    function automatic word_t rotr(input word_t v, input int n);
        return (v >> n) | (v << (WORD_W - n));
    endfunction

    function automatic word_t big_sigma0(input word_t v);
        return rotr(v, 2) ^ rotr(v, 13) ^ rotr(v, 22);
    endfunction

    function automatic word_t big_sigma1(input word_t v);
        return rotr(v, 6) ^ rotr(v, 11) ^ rotr(v, 25);
    endfunction

    function automatic word_t choose(input word_t s, input word_t p, input word_t q);
        return (s & p) | (~s & q);
    endfunction

    function automatic word_t majority(input word_t p, input word_t q, input word_t r);
        return (p & q) | (p & r) | (q & r);
    endfunction

endpackage

// File: rtl/sha4r_round.sv
module sha4r_round
    import sha4r_pkg::*;
(
    input  quad_t x_in,
    input  quad_t y_in,
    input  word_t k_in,
    output quad_t x_out,
    output quad_t y_out
);

    word_t t_sum;
    word_t x_top;
    word_t y_top;

    always_comb begin
        t_sum = y_in[LANES-1] + big_sigma1(y_in[0])
              + choose(y_in[0], y_in[1], y_in[2]) + k_in;
        x_top = x_in[LANES-1] + t_sum;
        y_top = t_sum + big_sigma0(x_in[0]) + majority(x_in[0], x_in[1], x_in[2]);
    end

    // Lanes move up by one; the two fresh words cross halves into lane 0.
    for (genvar i = 1; i < LANES; i++) begin : g_shift
        assign x_out[i] = x_in[i-1];
        assign y_out[i] = y_in[i-1];
    end
    assign x_out[0] = y_top;
    assign y_out[0] = x_top;

endmodule

// File: rtl/sha4r_fsm.sv
module sha4r_fsm
    import sha4r_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic             load,
    output logic             step,
    output logic             done,
    output logic             busy,
    output logic [CNT_W-1:0] rnd
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(LANES - 1);

    state_t           state_q, state_d;
    logic [CNT_W-1:0] rnd_q, rnd_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            rnd_q   <= '0;
        end else begin
            state_q <= state_d;
            rnd_q   <= rnd_d;
        end
    end

    always_comb begin
        state_d = state_q;
        rnd_d   = rnd_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_RUN;
                    rnd_d   = '0;
                end
            end
            ST_RUN: begin
                if (rnd_q == LAST) begin
                    state_d = ST_DONE;
                end else begin
                    rnd_d = rnd_q + 1'b1;
                end
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        load = (state_q == ST_IDLE) && start;
        step = (state_q == ST_RUN);
        done = (state_q == ST_DONE);
        busy = (state_q != ST_IDLE);
        rnd  = rnd_q;
    end

endmodule

// File: rtl/sha256_quad_round.sv
module sha256_quad_round
    import sha4r_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              part2,
    input  logic [QUAD_W-1:0] dst_in,
    input  logic [QUAD_W-1:0] src_in,
    input  logic [QUAD_W-1:0] wk_in,
    output logic              done,
    output logic [QUAD_W-1:0] result
);

    logic             load;
    logic             step;
    logic             busy;
    logic [CNT_W-1:0] rnd;

    quad_t x_q, y_q, k_q;
    quad_t x_nx, y_nx;
    logic  mode_q;

    sha4r_fsm u_fsm (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .load  (load),
        .step  (step),
        .done  (done),
        .busy  (busy),
        .rnd   (rnd)
    );

    sha4r_round u_round (
        .x_in  (x_q),
        .y_in  (y_q),
        .k_in  (k_q[rnd]),
        .x_out (x_nx),
        .y_out (y_nx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            x_q    <= '0;
            y_q    <= '0;
            k_q    <= '0;
            mode_q <= 1'b0;
        end else if (load) begin
            mode_q <= part2;
            x_q    <= part2 ? src_in : dst_in;
            y_q    <= part2 ? dst_in : src_in;
            k_q    <= wk_in;
        end else if (step) begin
            x_q <= x_nx;
            y_q <= y_nx;
        end
    end

    assign result = mode_q ? y_q : x_q;

endmodule

// File: rtl/sha4r_checker.sv
module sha4r_checker
    import sha4r_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              done,
    input logic              busy,
    input logic              step,
    input logic [CNT_W-1:0]  rnd,
    input logic [QUAD_W-1:0] result
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(LANES - 1);

    p_launch_r2: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (step && rnd == '0));

    p_round_advance_r8: assert property (@(posedge clk) disable iff (rst)
        (step && rnd != LAST) |=> (step && rnd == CNT_W'($past(rnd) + 1'b1)));

    p_done_after_last_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(step) && $past(rnd) == LAST));

    p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_result_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!step && !(start && !busy)) |=> $stable(result));

endmodule

bind sha256_quad_round sha4r_checker u_chk (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .done   (done),
    .busy   (busy),
    .step   (step),
    .rnd    (rnd),
    .result (result)
);

// File: tb/sha256_quad_round_test.sv
module sha256_quad_round_test;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic         part2 = 1'b0;
    logic [127:0] dst_in = '0;
    logic [127:0] src_in = '0;
    logic [127:0] wk_in = '0;
    logic         done;
    logic [127:0] result;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    sha256_quad_round uut (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .part2  (part2),
        .dst_in (dst_in),
        .src_in (src_in),
        .wk_in  (wk_in),
        .done   (done),
        .result (result)
    );

    // {mode, dst, src, key}
    localparam logic [384:0] VEC [7] = '{
        {1'b0, 128'h0, 128'h0, 128'h0},
        {1'b0, 128'ha54ff53a_3c6ef372_bb67ae85_6a09e667,
               128'h5be0cd19_1f83d9ab_9b05688c_510e527f,
               128'he9b5dba5_b5c0fbcf_71374491_428a2f98},
        {1'b1, 128'h5be0cd19_1f83d9ab_9b05688c_510e527f,
               128'ha54ff53a_3c6ef372_bb67ae85_6a09e667,
               128'he9b5dba5_b5c0fbcf_71374491_428a2f98},
        {1'b0, 128'h0, 128'h0, 128'h00000000_00000000_00000000_00000001},
        {1'b0, 128'h0, 128'h0, 128'h00000001_00000000_00000000_00000000},
        {1'b1, {32{4'hf}}, 128'h01234567_89abcdef_fedcba98_76543210,
               128'hdeadbeef_cafef00d_8badf00d_feedface},
        {1'b0, {32{4'hf}}, 128'h01234567_89abcdef_fedcba98_76543210,
               128'hdeadbeef_cafef00d_8badf00d_feedface}
    };

    function automatic logic [31:0] rr(input logic [31:0] v, input int n);
        logic [63:0] dbl;
        dbl = {v, v} >> n;
        return dbl[31:0];
    endfunction

    function automatic logic [127:0] model(input logic p2, input logic [127:0] d,
                                           input logic [127:0] s, input logic [127:0] k);
        logic [127:0] hi_abcd, hi_efgh;
        logic [31:0] a, b, c, dd, e, f, g, h, t1, t2;
        hi_abcd = p2 ? s : d;
        hi_efgh = p2 ? d : s;
        {dd, c, b, a} = hi_abcd;
        {h, g, f, e}  = hi_efgh;
        for (int r = 0; r < 4; r++) begin
            t1 = h + (rr(e, 6) ^ rr(e, 11) ^ rr(e, 25)) + ((e & f) ^ (~e & g)) + k[r*32 +: 32];
            t2 = (rr(a, 2) ^ rr(a, 13) ^ rr(a, 22)) + ((a & b) ^ (a & c) ^ (b & c));
            h = g; g = f; f = e; e = dd + t1;
            dd = c; c = b; b = a; a = t1 + t2;
        end
        return p2 ? {h, g, f, e} : {dd, c, b, a};
    endfunction

    task automatic chk128(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk1(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %b expected %b", req, act, exp);
        end
    endtask

    // Leaves the bench at the falling edge after the accepting edge.
    task automatic launch(input logic p2, input logic [127:0] d,
                          input logic [127:0] s, input logic [127:0] k);
        @(negedge clk);
        start = 1'b1; part2 = p2; dst_in = d; src_in = s; wk_in = k;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Checks R6 timing; returns at the falling edge where done is high.
    task automatic await_done();
        int early = 0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            if (done) early++;
        end
        chk1("R6 no early done", early == 0, 1'b1);
        @(negedge clk);
        chk1("R6 done on fifth edge", done, 1'b1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [127:0] exp_a;
        int seen;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk1("R1 done low in reset", done, 1'b0);
        chk128("R1 result zero in reset", result, '0);
        rst = 1'b0;

        // Table of vectors: R2, R3, R4, R5, R9
        for (int v = 0; v < 7; v++) begin
            launch(VEC[v][384], VEC[v][383:256], VEC[v][255:128], VEC[v][127:0]);
            await_done();
            exp_a = model(VEC[v][384], VEC[v][383:256], VEC[v][255:128], VEC[v][127:0]);
            chk128(VEC[v][384] ? "R3 R4 second-half result" : "R2 R4 first-half result",
                   result, exp_a);
            @(negedge clk);
            chk1("R6 done lasts one cycle", done, 1'b0);
        end

        // R9: zero in, zero out
        launch(1'b0, '0, '0, '0);
        await_done();
        chk128("R9 zero operands", result, '0);

        // R5: lane 0 and lane 3 keys must give distinct, model-matching results
        launch(1'b0, '0, '0, 128'h1);
        await_done();
        exp_a = result;
        launch(1'b0, '0, '0, {32'h1, 96'h0});
        await_done();
        chk1("R5 lane order matters", exp_a != result, 1'b1);
        chk128("R5 lane3 key", result, model(1'b0, '0, '0, {32'h1, 96'h0}));

        // R7: hold after done while inputs wiggle without start
        exp_a = result;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            dst_in = ~dst_in; src_in = src_in + 128'd7; wk_in = ~wk_in; part2 = ~part2;
        end
        chk128("R7 result held", result, exp_a);
        chk1("R7 no spurious done", done, 1'b0);

        // R8: start during RUN
        launch(1'b0, VEC[1][383:256], VEC[1][255:128], VEC[1][127:0]);
        @(negedge clk);
        start = 1'b1; part2 = 1'b1; dst_in = '1; src_in = '0; wk_in = '1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk1("R8 done unaffected by busy start", done, 1'b1);
        exp_a = model(1'b0, VEC[1][383:256], VEC[1][255:128], VEC[1][127:0]);
        chk128("R8 original operands kept", result, exp_a);
        // R8: start during DONE
        start = 1'b1; dst_in = 128'h5; src_in = 128'h9; wk_in = 128'h3;
        @(negedge clk);
        start = 1'b0;
        seen = 0;
        for (int i = 0; i < 7; i++) begin
            @(negedge clk);
            if (done) seen++;
        end
        chk1("R8 start in done ignored", seen == 0, 1'b1);
        chk128("R8 result unchanged", result, exp_a);

        // R1: reset mid-operation
        launch(1'b1, VEC[5][383:256], VEC[5][255:128], VEC[5][127:0]);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk128("R1 result cleared by reset", result, '0);
        rst = 1'b0;
        seen = 0;
        for (int i = 0; i < 7; i++) begin
            @(negedge clk);
            if (done) seen++;
        end
        chk1("R1 abandoned operation gives no done", seen == 0, 1'b1);

        // Recovery after reset
        launch(1'b1, VEC[5][383:256], VEC[5][255:128], VEC[5][127:0]);
        await_done();
        chk128("R3 after reset", result,
               model(1'b1, VEC[5][383:256], VEC[5][255:128], VEC[5][127:0]));

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule